// File: doc/BRIEF.md
# Linear image sensor timing generator

This block drives a linear light-sensor array from one system clock. It produces three waveforms with a fixed phase relationship between them. The first is a free-running master clock. The second is a shift-gate pulse that opens and closes the light-integration window. The third is a clear-gate pulse that brackets the shift pulse. After the clear gate returns high, the block emits one single-cycle sample strobe per pixel, together with the index of that pixel, so that an external converter can capture the analog output of the sensor.

Each frame lasts a programmable number of system-clock cycles. A frame opens when the clear gate falls. The shift gate rises a guard delay later and stays high for a programmed width. After a second guard delay the clear gate rises again, and pixel readout begins. Readout runs at one pixel per two master-clock periods and stops after a fixed number of pixels. The configuration inputs are captured only when a frame starts, so changing them never disturbs a frame in progress. When the enable input is dropped, the block completes the current frame and then parks.

Top module: `lsa_timing_gen`

## Requirements
- R1: During reset and while parked, the outputs hold these values: clr_gate=1, sh_gate=0, mclk=0, pix_strobe=0 and frame_start=0. Reset also sets pix_idx to 0.
- R2: While en is high, a frame lasts P cycles, where P = max(cfg_period, 2), and frames follow one another back to back. In each frame, clr_gate is low for exactly T2+W+T1 cycles starting at the first cycle of the frame, and high for the rest of the frame.
- R3: sh_gate rises T2 cycles after clr_gate falls and stays high for exactly W cycles.
- R4: clr_gate rises exactly T1 cycles after sh_gate falls.
- R5: The effective settings are clamped to a minimum of 1: T1 = max(cfg_t1, 1), T2 = max(cfg_t2, 1) and W = max(cfg_sh, 1).
- R6: mclk has a period of D cycles, where D = max(cfg_mdiv, 2). It is high for the first floor(D/2) cycles of each period. The divider restarts at every frame start, so a rising edge of mclk coincides with the first cycle of each frame.
- R7: pix_strobe is a one-cycle pulse. The first pulse of a frame falls on the first mclk rising edge at or after the clr_gate rising edge. Later pulses follow every 2·D cycles, and there are exactly NPIX pulses per frame.
- R8: pix_idx changes together with each pix_strobe pulse and takes the values 0, 1, …, NPIX-1 in order. After the last pulse it holds NPIX-1 until the next frame's strobes.
- R9: frame_start is high for exactly one cycle per frame, in the first cycle in which clr_gate is low.
- R10: Changes to cfg_period, cfg_t1, cfg_t2, cfg_sh and cfg_mdiv made during a frame have no effect until the next frame starts.
- R11: When en is dropped during a frame, that frame completes unchanged and the outputs then return to the R1 parked values. When en is raised again, a new frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| en | input | 1 | Run frames while high |
| cfg_period | input | CNT_W | Frame length in cycles |
| cfg_t1 | input | GW | Guard delay from shift-gate fall to clear-gate rise |
| cfg_t2 | input | GW | Guard delay from clear-gate fall to shift-gate rise |
| cfg_sh | input | GW | Shift-gate high width in cycles |
| cfg_mdiv | input | DIV_W | Master-clock divide ratio |
| mclk | output | 1 | Sensor master clock |
| sh_gate | output | 1 | Shift-gate drive |
| clr_gate | output | 1 | Clear-gate drive |
| pix_strobe | output | 1 | One-cycle sample strobe per pixel |
| pix_idx | output | $clog2(NPIX) | Index of the strobed pixel |
| frame_start | output | 1 | One-cycle flag at the clear-gate fall |

## Verification
The case hardest to reach from the ports is a configuration change that arrives in the middle of a frame. To expose it, the bench rewrites every setting about forty cycles into a frame. It then checks that the remainder of that frame still follows the old timing on every cycle, and that the following frame follows the new timing on every cycle. Draining the frame after en drops is a second hard case. The bench covers it by lowering en at a frame's first cycle, checking the whole frame, and then watching the parked outputs for several frame lengths. Every cycle of every checked frame is compared against edge positions that the bench computes arithmetically. This includes an odd divide ratio and settings of zero, which must be clamped.

// File: rtl/lsg_pkg.sv
`timescale 1ns/1ps
package lsg_pkg;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_RUN  = 1'b1
  } fstate_e;

  typedef struct packed {
    logic first;    // first cycle of a frame
    logic icg_low;  // clear gate held low
    logic sh_hi;    // shift gate high
    logic in_read;  // readout window open
  } phase_t;

endpackage

// File: rtl/lsg_frame_seq.sv
`timescale 1ns/1ps
module lsg_frame_seq
  import lsg_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int GW    = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [GW-1:0]    cfg_t1,
  input  logic [GW-1:0]    cfg_t2,
  input  logic [GW-1:0]    cfg_sh,
  input  logic [DIV_W-1:0] cfg_mdiv,
  output logic             run,
  output logic             load,
  output logic [DIV_W-1:0] mdiv_s,
  output phase_t           phase
);

  localparam logic [CNT_W-1:0] PER_MIN = CNT_W'(2);
  localparam logic [GW-1:0]    ONE_G   = GW'(1);
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

  fstate_e          st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] per_s, t2_s, shend_s, low_s;
  logic [CNT_W-1:0] per_c, t1_c, t2_c, sh_c;
  logic [DIV_W-1:0] mdiv_c;
  logic             last;

  // clamp the raw settings
  always_comb begin
    per_c  = (cfg_period < PER_MIN) ? PER_MIN : cfg_period;
    t1_c   = CNT_W'((cfg_t1 == '0) ? ONE_G : cfg_t1);
    t2_c   = CNT_W'((cfg_t2 == '0) ? ONE_G : cfg_t2);
    sh_c   = CNT_W'((cfg_sh == '0) ? ONE_G : cfg_sh);
    mdiv_c = (cfg_mdiv < DIV_MIN) ? DIV_MIN : cfg_mdiv;
  end

  assign run  = (st_q == FS_RUN);
  assign last = run && (cnt_q == per_s - CNT_W'(1));
  assign load = en && (!run || last);

  // next state
  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    if (load) begin
      st_n  = FS_RUN;
      cnt_n = '0;
    end else if (last) begin
      st_n  = FS_IDLE;
      cnt_n = '0;
    end else if (run) begin
      cnt_n = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  // shadow settings, captured only at a frame start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_s   <= PER_MIN;
      t2_s    <= CNT_W'(1);
      shend_s <= CNT_W'(2);
      low_s   <= CNT_W'(3);
      mdiv_s  <= DIV_MIN;
    end else if (load) begin
      per_s   <= per_c;
      t2_s    <= t2_c;
      shend_s <= t2_c + sh_c;
      low_s   <= t2_c + sh_c + t1_c;
      mdiv_s  <= mdiv_c;
    end
  end

  always_comb begin
    phase.first   = run && (cnt_q == '0);
    phase.icg_low = run && (cnt_q < low_s);
    phase.sh_hi   = run && (cnt_q >= t2_s) && (cnt_q < shend_s);
    phase.in_read = run && (cnt_q >= low_s);
  end

  // R10: shadows are frozen between frame starts
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(low_s) && $stable(shend_s) && $stable(per_s) && $stable(mdiv_s)));

  // R5: the shift window always sits strictly inside the low window
  p_guard_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (t2_s != '0) && (shend_s > t2_s) && (low_s > shend_s));

  // R2: the frame counter never passes the frame length
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < per_s);

endmodule

// File: rtl/lsg_mclk_div.sv
`timescale 1ns/1ps
module lsg_mclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [DIV_W-1:0] mdiv_s,
  output logic             lvl,
  output logic             tick
);

  logic [DIV_W-1:0] mcnt_q, mcnt_n;

  always_comb begin
    if (load || !run) begin
      mcnt_n = '0;
    end else if (mcnt_q == mdiv_s - DIV_W'(1)) begin
      mcnt_n = '0;
    end else begin
      mcnt_n = mcnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mcnt_q <= '0;
    else        mcnt_q <= mcnt_n;
  end

  assign lvl  = run && (mcnt_q < (mdiv_s >> 1));
  assign tick = run && (mcnt_q == '0);

  // R6: divider count stays below the ratio
  p_mcnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (mcnt_q < mdiv_s));

endmodule

// File: rtl/lsg_pix_seq.sv
`timescale 1ns/1ps
module lsg_pix_seq #(
  parameter int NPIX  = 1576,
  parameter int PCW   = $clog2(NPIX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           in_read,
  input  logic           tick,
  output logic           strobe,
  output logic [PCW-1:0] pcount
);

  localparam logic [PCW-1:0] NPIX_C = PCW'(NPIX);

  logic           half_q, half_n;
  logic [PCW-1:0] pc_q, pc_n;

  assign strobe = in_read && tick && !half_q && (pc_q < NPIX_C);
  assign pcount = pc_q;

  always_comb begin
    half_n = half_q;
    pc_n   = pc_q;
    if (load) begin
      half_n = 1'b0;
      pc_n   = '0;
    end else if (in_read && tick) begin
      half_n = ~half_q;
      if (strobe) pc_n = pc_q + PCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      pc_q   <= '0;
    end else begin
      half_q <= half_n;
      pc_q   <= pc_n;
    end
  end

  // R7: never more than NPIX strobes in a frame
  p_pix_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= NPIX_C);

endmodule

// File: rtl/lsa_timing_gen.sv
`timescale 1ns/1ps
module lsa_timing_gen
  import lsg_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int GW    = 16,
  parameter int DIV_W = 8,
  parameter int NPIX  = 1576,
  localparam int PIX_W = $clog2(NPIX),
  localparam int PCW   = $clog2(NPIX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [GW-1:0]    cfg_t1,
  input  logic [GW-1:0]    cfg_t2,
  input  logic [GW-1:0]    cfg_sh,
  input  logic [DIV_W-1:0] cfg_mdiv,
  output logic             mclk,
  output logic             sh_gate,
  output logic             clr_gate,
  output logic             pix_strobe,
  output logic [PIX_W-1:0] pix_idx,
  output logic             frame_start
);

  logic             run, load, mlvl, mtick, strb_c;
  logic [DIV_W-1:0] mdiv_s;
  logic [PCW-1:0]   pcount;
  phase_t           phase;

  lsg_frame_seq #(.CNT_W(CNT_W), .GW(GW), .DIV_W(DIV_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cfg_period(cfg_period), .cfg_t1(cfg_t1), .cfg_t2(cfg_t2),
    .cfg_sh(cfg_sh), .cfg_mdiv(cfg_mdiv),
    .run(run), .load(load), .mdiv_s(mdiv_s), .phase(phase)
  );

  lsg_mclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .load(load),
    .mdiv_s(mdiv_s), .lvl(mlvl), .tick(mtick)
  );

  lsg_pix_seq #(.NPIX(NPIX), .PCW(PCW)) u_pix (
    .clk(clk), .rst_n(rst_n), .load(load), .in_read(phase.in_read),
    .tick(mtick), .strobe(strb_c), .pcount(pcount)
  );

  // registered outputs
  logic             mclk_n, sh_n, icg_n, strb_n, fs_n;
  logic [PIX_W-1:0] idx_n;

  always_comb begin
    mclk_n = mlvl;
    sh_n   = phase.sh_hi;
    icg_n  = !phase.icg_low;
    strb_n = strb_c;
    fs_n   = phase.first;
    idx_n  = strb_c ? pcount[PIX_W-1:0] : pix_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mclk        <= 1'b0;
      sh_gate     <= 1'b0;
      clr_gate    <= 1'b1;
      pix_strobe  <= 1'b0;
      frame_start <= 1'b0;
      pix_idx     <= '0;
    end else begin
      mclk        <= mclk_n;
      sh_gate     <= sh_n;
      clr_gate    <= icg_n;
      pix_strobe  <= strb_n;
      frame_start <= fs_n;
      pix_idx     <= idx_n;
    end
  end

  // R3: shift gate only inside the clear-gate low window
  p_sh_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sh_gate |-> !clr_gate);

  // R5: shift rise leaves a guard after the clear fall
  p_t2_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_gate) |-> $past(!clr_gate));

  // R4: clear gate still low after shift falls
  p_t1_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sh_gate) |-> !clr_gate);

  // R9: frame flag marks the clear-gate fall
  p_fs_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (!clr_gate && mclk));

  // R7: strobes ride an mclk rising edge inside readout
  p_strobe_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_strobe |-> ($rose(mclk) && clr_gate));

endmodule

// File: tb/lsa_timing_gen_bench.sv
`timescale 1ns/1ps
module lsa_timing_gen_bench;

  localparam int CNT_W = 20;
  localparam int GW    = 16;
  localparam int DIV_W = 8;
  localparam int NPIX  = 8;
  localparam int PIX_W = $clog2(NPIX);

  logic             clk = 1'b0;
  logic             rst_n, en;
  logic [CNT_W-1:0] cfg_period;
  logic [GW-1:0]    cfg_t1, cfg_t2, cfg_sh;
  logic [DIV_W-1:0] cfg_mdiv;
  logic             mclk, sh_gate, clr_gate, pix_strobe, frame_start;
  logic [PIX_W-1:0] pix_idx;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  lsa_timing_gen #(.CNT_W(CNT_W), .GW(GW), .DIV_W(DIV_W), .NPIX(NPIX)) u_lsa_timing_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_period(cfg_period),
    .cfg_t1(cfg_t1), .cfg_t2(cfg_t2), .cfg_sh(cfg_sh), .cfg_mdiv(cfg_mdiv),
    .mclk(mclk), .sh_gate(sh_gate), .clr_gate(clr_gate),
    .pix_strobe(pix_strobe), .pix_idx(pix_idx), .frame_start(frame_start)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input int o, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s at offset %0d: act=%0d exp=%0d", req, o, act, exp);
    end
  endtask

  task automatic setcfg(input int p, input int t1, input int t2, input int sh, input int md);
    cfg_period = CNT_W'(p);
    cfg_t1     = GW'(t1);
    cfg_t2     = GW'(t2);
    cfg_sh     = GW'(sh);
    cfg_mdiv   = DIV_W'(md);
  endtask

  // Entered at the negedge of a frame's first output cycle; leaves at the next frame's.
  task automatic check_frame(input int p, input int t1, input int t2, input int sh, input int md);
    int low, s0, step;
    low  = t2 + sh + t1;
    s0   = ((low + md - 1) / md) * md;
    step = 2 * md;
    for (int o = 0; o < p; o++) begin
      bit st_e;
      int j;
      j    = (o - s0) / step;
      st_e = (o >= s0) && ((o - s0) % step == 0) && (j < NPIX);
      chk("R2 clr_gate", o, clr_gate, (o >= low) ? 1 : 0);
      chk("R3 sh_gate", o, sh_gate, (o >= t2 && o < t2 + sh) ? 1 : 0);
      chk("R6 mclk", o, mclk, ((o % md) < md / 2) ? 1 : 0);
      chk("R9 frame_start", o, frame_start, (o == 0) ? 1 : 0);
      chk("R7 pix_strobe", o, pix_strobe, st_e ? 1 : 0);
      if (st_e) chk("R8 pix_idx", o, pix_idx, j);
      if (o == p - 1) chk("R8 pix_idx hold", o, pix_idx, NPIX - 1);
      if (o == t2 + sh + t1) chk("R4 clr rise after t1", o, clr_gate, 1);
      @(negedge clk);
    end
  endtask

  task automatic wait_fs();
    int n = 0;
    while (!frame_start && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk("R11 frame begins", n, frame_start, 1);
  endtask

  task automatic check_idle(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      chk(req, i, {clr_gate, sh_gate, mclk, pix_strobe, frame_start}, 5'b10000);
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    en    = 1'b0;
    setcfg(200, 3, 4, 6, 4);
    repeat (3) @(negedge clk);
    check_idle("R1 reset", 2);
    chk("R1 reset idx", 0, pix_idx, 0);
    rst_n = 1'b1;
    check_idle("R1 parked", 5);

    en = 1'b1;
    wait_fs();
    check_frame(200, 3, 4, 6, 4);
    check_frame(200, 3, 4, 6, 4);   // R2 back to back

    // R10: change every setting mid-frame
    fork
      check_frame(200, 3, 4, 6, 4);
      begin
        repeat (40) @(negedge clk);
        setcfg(150, 2, 5, 9, 5);
      end
    join
    check_frame(150, 2, 5, 9, 5);

    // R5: zero settings clamp to 1, divider to 2
    setcfg(120, 0, 0, 0, 1);
    check_frame(150, 2, 5, 9, 5);
    check_frame(120, 1, 1, 1, 2);

    // R11: drop enable at frame start, frame completes, then park
    en = 1'b0;
    check_frame(120, 1, 1, 1, 2);
    check_idle("R11 parked after drain", 400);
    setcfg(90, 2, 3, 4, 3);
    en = 1'b1;
    wait_fs();
    check_frame(90, 2, 3, 4, 3);
    finish_run();
  end

endmodule